// File: doc/BRIEF.md
# Stable-Level Duration Detector

The block watches one already-synchronized digital input and measures how long it has gone without changing. One elapsed-time counter is restarted by every change of the input, whether the change is upward or downward. The counter advances once for each pulse of a 1 ms tick strobe, so it holds the number of milliseconds since the last change. The counter is compared with a programmed threshold to answer three questions. Has the input held high for at least that long? Has it held low for at least that long? Has it held at either level for at least that long?

The third answer is meant for watchdog duty. A square wave whose resting level after it stops is not known can be watched with that one flag: the flag stays low while the wave keeps toggling faster than the threshold, and it rises once the wave has stopped at either level. Short glitches on a quiet input restart the measurement, so they are filtered out of all three answers. The block also returns the level it has sampled from the input.

The control part registers the input level, detects changes and issues counter strobes. The datapath part holds the saturating counter and the threshold comparison.

Top module: `stable_level_monitor`

## Requirements
- R1: Any change of `sigIn` in either direction restarts the elapsed count at 0. In the cycle after the clock edge that samples the change, `stableHigh`, `stableLow` and `stableAny` are all 0 whenever `threshold` is nonzero.
- R2: The elapsed count rises by one on each clock edge that samples `msTick`=1 with no change of `sigIn`. On any other edge it holds its value.
- R3: `stableHigh` is 1 exactly when the elapsed count is at least `threshold` and `levelNow` is 1.
- R4: `stableLow` is 1 exactly when the elapsed count is at least `threshold` and `levelNow` is 0.
- R5: `stableAny` is 1 exactly when the elapsed count is at least `threshold`, at either level. A change of `threshold` takes effect on the flags in the same cycle.
- R6: The comparison is inclusive. Once `threshold` ticks have been counted since the last change, the flags are asserted.
- R7: An input that changes again before `threshold` ticks have been counted keeps all three flags at 0.
- R8: The elapsed count saturates at 2^CNT_W-1 and does not wrap. A quiet input with `threshold` = 2^CNT_W-1 keeps `stableAny` asserted while further ticks arrive.
- R9: While `rst_n` is 0, the count is 0, `levelNow` is 0 and all flags are 0 (for a nonzero threshold), whatever the inputs. After release, the flags rise only after `threshold` ticks have been counted.
- R10: When a change of `sigIn` and a tick are sampled on the same edge, the restart takes priority and the count becomes 0, not 1.
- R11: `levelNow` equals the value of `sigIn` sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sigIn | input | 1 | Synchronized input level to watch |
| msTick | input | 1 | One-clock strobe, once per millisecond |
| threshold | input | CNT_W | Required quiet time in ticks |
| levelNow | output | 1 | Registered input level |
| stableHigh | output | 1 | High for at least threshold ticks |
| stableLow | output | 1 | Low for at least threshold ticks |
| stableAny | output | 1 | Unchanged for at least threshold ticks |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- Exact equality of the count and the threshold. A strict comparison would report stability one tick late.
- A change arriving on the same edge as a tick. A design that let the tick win would begin the new interval at 1 and flag one tick early.
- A counter held at its full value with the largest threshold. A wrapping counter would drop `stableAny` once it rolled over to zero.
- Toggling faster than the threshold, and raising the threshold while stable. These expose flags that hold a stale result or that ignore the level.

// File: rtl/slm_pkg.sv
package slm_pkg;

  // Strobes from control to the elapsed-time datapath
  typedef struct packed {
    logic clearCnt;  // restart the elapsed count
    logic incCnt;    // advance the elapsed count by one
  } cntStrobes_t;

endpackage

// File: rtl/slm_ctrl.sv
module slm_ctrl
  import slm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sigIn,
  input  logic        msTick,
  input  logic        cntAtMax,
  output cntStrobes_t strobes,
  output logic        levelNow
);

  logic levelReg;
  logic changeSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) levelReg <= 1'b0;
    else        levelReg <= sigIn;
  end

  // A change in either direction restarts the measurement
  assign changeSeen = sigIn ^ levelReg;

  always_comb begin
    strobes.clearCnt = changeSeen;
    // Restart wins over a coincident tick; a full counter stops advancing
    strobes.incCnt   = msTick && !changeSeen && !cntAtMax;
  end

  assign levelNow = levelReg;

  // R11
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> levelNow == $past(sigIn));

endmodule

// File: rtl/slm_datapath.sv
module slm_datapath
  import slm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntStrobes_t      strobes,
  input  logic [CNT_W-1:0] threshold,
  input  logic             levelNow,
  output logic             cntAtMax,
  output logic             stableHigh,
  output logic             stableLow,
  output logic             stableAny
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] elapsed;
  logic             reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                elapsed <= '0;
    else if (strobes.clearCnt) elapsed <= '0;
    else if (strobes.incCnt)   elapsed <= elapsed + CNT_ONE;
  end

  assign cntAtMax = (elapsed == CNT_MAX);
  assign reached  = (elapsed >= threshold);

  always_comb begin
    stableAny  = reached;
    stableHigh = reached &&  levelNow;
    stableLow  = reached && !levelNow;
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cntAtMax && !strobes.clearCnt) |=> cntAtMax);

  // R1
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearCnt |=> elapsed == '0);

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.clearCnt && !strobes.incCnt) |=> $stable(elapsed));

endmodule

// File: rtl/stable_level_monitor.sv
module stable_level_monitor
  import slm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sigIn,
  input  logic             msTick,
  input  logic [CNT_W-1:0] threshold,
  output logic             levelNow,
  output logic             stableHigh,
  output logic             stableLow,
  output logic             stableAny
);

  cntStrobes_t strobes;
  logic        cntAtMax;

  slm_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sigIn    (sigIn),
    .msTick   (msTick),
    .cntAtMax (cntAtMax),
    .strobes  (strobes),
    .levelNow (levelNow)
  );

  slm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .threshold  (threshold),
    .levelNow   (levelNow),
    .cntAtMax   (cntAtMax),
    .stableHigh (stableHigh),
    .stableLow  (stableLow),
    .stableAny  (stableAny)
  );

  // R1
  change_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sigIn != levelNow) |=> (!stableAny || threshold == '0));

  // R3
  high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stableHigh |-> (levelNow && stableAny));

  // R4
  low_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stableLow |-> (!levelNow && stableAny));

  // R5
  either_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stableHigh, stableLow}) == (stableAny ? 1 : 0));

  // R8
  quiet_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stableAny && sigIn == levelNow) |=> (stableAny || threshold != $past(threshold)));

endmodule

// File: tb/test_stable_level_monitor.sv
module test_stable_level_monitor;

  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic sigIn;
  logic msTick;
  logic [CNT_W-1:0] threshold;
  logic levelNow, stableHigh, stableLow, stableAny;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  stable_level_monitor #(.CNT_W(CNT_W)) i_stable_level_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sigIn      (sigIn),
    .msTick     (msTick),
    .threshold  (threshold),
    .levelNow   (levelNow),
    .stableHigh (stableHigh),
    .stableLow  (stableLow),
    .stableAny  (stableAny)
  );

  // Vector fields: {sigIn, msTick, expHigh, expLow, expAny, expLevel}, threshold = 3
  localparam int NVEC = 20;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b01_0000, // count 1
    6'b01_0000, // count 2
    6'b00_0000, // no tick, hold 2 (R2)
    6'b01_0110, // count 3 equals threshold: low (R6, R4)
    6'b11_0001, // rise with tick: restart wins (R10, R1)
    6'b11_0001, // 1
    6'b11_0001, // 2
    6'b11_1011, // 3: high (R3, R5)
    6'b11_1011, // 4
    6'b00_0000, // fall, restart (R1)
    6'b11_0001, // fast toggle (R7)
    6'b11_0001, // 1
    6'b01_0000, // fall again (R7)
    6'b01_0000, // 1
    6'b01_0000, // 2
    6'b11_0001, // rise before threshold (R7)
    6'b11_0001, // 1
    6'b11_0001, // 2
    6'b10_0001, // no tick (R2)
    6'b11_1011  // 3: high (R11 level follows)
  };

  task automatic checkOut(input string req, input logic eH, input logic eL,
                          input logic eA, input logic eLv);
    nChecks++;
    if ({stableHigh, stableLow, stableAny, levelNow} !== {eH, eL, eA, eLv}) begin
      nFails++;
      $display("FAIL %s: got H/L/A/lvl=%b%b%b%b expected %b%b%b%b at %0t",
               req, stableHigh, stableLow, stableAny, levelNow, eH, eL, eA, eLv, $time);
    end
  endtask

  // Drive inputs, let one clock edge take them, sample 2 ns after the edge
  task automatic step(input logic s, input logic t);
    sigIn  = s;
    msTick = t;
    @(posedge clk);
    #2;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got running expected finished");
    finish();
  end

  initial begin
    rst_n = 1'b0;
    sigIn = 1'b0;
    msTick = 1'b0;
    threshold = 16'd3;
    @(posedge clk); #2;
    // R9: inputs active during reset have no effect
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    checkOut("R9 reset holds", 1'b0, 1'b0, 1'b0, 1'b0);
    sigIn = 1'b0;
    msTick = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #2;
    checkOut("R9 after release", 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][5], VEC[i][4]);
      checkOut($sformatf("R1-table vector %0d", i),
               VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R5 / R6: count is 3, high; raising threshold to 4 drops the flags at once
    threshold = 16'd4;
    #1;
    checkOut("R5 threshold raised", 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1);
    checkOut("R6 count equals new threshold", 1'b1, 1'b0, 1'b1, 1'b1);

    // R8: saturation with the largest threshold
    threshold = FULL;
    step(1'b0, 1'b1);
    checkOut("R1 fall before saturation run", 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 65534; k++) step(1'b0, 1'b1);
    checkOut("R8 one below full", 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1);
    checkOut("R8 reached full", 1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) step(1'b0, 1'b1);
    checkOut("R8 no wrap", 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0);
    checkOut("R1 change at full count", 1'b0, 1'b0, 1'b0, 1'b1);

    // R9: reset in the middle of operation
    threshold = 16'd2;
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    checkOut("R3 high before reset", 1'b1, 1'b0, 1'b1, 1'b1);
    rst_n = 1'b0;
    #1;
    checkOut("R9 async reset clears", 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b1);
    checkOut("R9 one tick after reset", 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1);
    checkOut("R9 full interval after reset", 1'b0, 1'b1, 1'b1, 1'b0);

    finish();
  end

endmodule